// File: doc/BRIEF.md
# Instruction Cycle Control Sequencer

This block is the timing and control heart of a small accumulator machine with 16-bit instruction words and a 12-bit address space. A 4-bit step counter produces sixteen one-hot timing lines. The first three steps fetch and decode an instruction:

- The program counter is copied into the address register.
- The word at that address is read into the instruction register, and the program counter advances.
- The 3-bit opcode is decoded into eight lines. The 12-bit address field is moved into the address register. The top bit of the word is captured as the addressing-mode flag.

At the fourth step, T3, the block classifies the instruction and takes one of four paths: direct memory operand, indirect memory operand, register operation or input-output operation.

On the indirect path the block performs one extra memory read at T3 and replaces the address register with the low 12 bits of the word it returns. The register and input-output paths are executed by a neighbouring unit during a one-cycle execute strobe at T3, after which the step counter returns to T0.

Memory-operand instructions leave the sequencer at T4 with the effective address in the address register. A handoff strobe marks that step. The executing unit returns the sequencer to T0 through a clear input. Memory reads are combinational: the address and the read strobe are valid in the cycle, and the read data is used at the next rising edge.

Top module: `icc_sequencer`

## Requirements
- R1: While synchronous reset is high, and on the edge that samples it, the step counter, PC, AR, IR and the mode flag all clear. After reset the step output is 0, only timing line 0 is high, and both strobes are low.
- R2: On every rising edge out of reset, the step counter either increments by one, wrapping from 15 to 0, or clears to 0. It never keeps its value. Exactly one timing line is high at any time, and it is the line whose index equals the step.
- R3: Fetch and decode proceed as follows:
  - In step 0, AR is loaded from PC.
  - In step 1, the read strobe is high and the memory address equals AR. IR is loaded from the read data and PC increments modulo 4096.
  - In step 2, AR takes IR bits 11:0 and the mode flag takes IR bit 15.
  - The decode output is always the one-hot code of IR bits 14:12: bit n is high for opcode n.
- R4: In step 3, when the opcode is not 111 and the mode flag is 1, the read strobe is high with the memory address equal to AR. At the edge, AR loads read-data bits 11:0 and the step becomes 4.
- R5: In step 3, when the opcode is not 111 and the mode flag is 0, the read strobe is low, AR keeps its value and the step becomes 4.
- R6: In step 3, when the opcode is 111, the execute strobe is high for that one cycle only, AR keeps its value and the step becomes 0. The execute strobe is low in every other step.
- R7: The kind output encodes the current decode line 7 and the mode flag: 0 means memory direct, 1 memory indirect, 2 register, 3 input-output. Line 7 low with the flag 0 or 1 gives kind 0 or 1. Line 7 high with the flag 0 or 1 gives kind 2 or 3.
- R8: The handoff strobe is high exactly in step 4 when the opcode is not 111.
- R9: The clear input returns the step to 0 at the next edge when the step is 4 or more. It has no effect in steps 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory read address, always equal to AR |
| mem_rdata | input | 16 | Combinational read data for mem_addr |
| mem_rd | output | 1 | Read strobe (fetch step and indirect step) |
| exec_clear | input | 1 | Return to T0 from an execution step (step 4 or more) |
| step | output | 4 | Current step counter value |
| timing | output | 16 | One-hot timing lines T0..T15 |
| dec | output | 8 | One-hot decode of IR opcode bits 14:12 |
| kind | output | 2 | Instruction kind: 0 direct, 1 indirect, 2 register, 3 input-output |
| ar | output | 12 | Address register |
| pc | output | 12 | Program counter |
| ibit | output | 1 | Addressing-mode flag |
| exec_stb | output | 1 | Execute strobe for register and input-output instructions (step 3) |
| handoff_stb | output | 1 | Memory-operand handoff strobe (step 4) |

## Verification
The bench sweeps all eight opcodes against both mode-flag values, with varied address fields, and places each indirect pointer word so that it differs from its own address.

Each target catches a specific fault:
- Checking AR after T3 catches a design that skips the indirect read (AR would still hold the pointer address) or that performs it on a direct instruction.
- Checking the step after T3 catches a register or input-output instruction that falls through to T4, or a memory instruction that clears back to T0.
- The clear input is pulsed during the fetch step to catch a sequencer that honours it too early and restarts the fetch.
- One memory instruction is left uncleared so that the counter must wrap from 15 to 0 rather than stall, and the following fetch must then still use the already incremented PC.

// File: rtl/icc_pkg.sv
package icc_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int OPC_W  = 3;
    localparam int SC_W   = 4;
    localparam int STEPS  = 1 << SC_W;
    localparam int DEC_N  = 1 << OPC_W;

    // first step in which the external clear is honoured
    localparam int EXEC_STEP = 4;

    typedef enum logic [1:0] {
        KIND_MEM_DIR = 2'd0,
        KIND_MEM_IND = 2'd1,
        KIND_REG     = 2'd2,
        KIND_IO      = 2'd3
    } kind_t;

    typedef struct packed {
        logic              ind;
        logic [OPC_W-1:0]  opc;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic ar_from_pc;
        logic ar_from_ir;
        logic ar_from_mem;
        logic ir_load;
        logic pc_inc;
        logic i_load;
    } dp_ctl_t;

    function automatic kind_t classify(input logic top_line, input logic mode);
        case ({top_line, mode})
            2'b00:   return KIND_MEM_DIR;
            2'b01:   return KIND_MEM_IND;
            2'b10:   return KIND_REG;
            default: return KIND_IO;
        endcase
    endfunction

endpackage

// File: rtl/icc_step_counter.sv
module icc_step_counter
    import icc_pkg::*;
#(
    parameter int CNT_W = SC_W,
    localparam int NLINES = 1 << CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    output logic [CNT_W-1:0]  cnt,
    output logic [NLINES-1:0] lines
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    for (genvar k = 0; k < NLINES; k++) begin : g_line
        assign lines[k] = (cnt == CNT_W'(k));
    end

    // R2: the counter never keeps its value
    a_r2_advance_or_clear: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (cnt == '0) || (cnt == $past(cnt) + 1'b1));

    a_r2_clear_works: assert property (@(posedge clk) disable iff (rst)
        clear |=> cnt == '0);

endmodule

// File: rtl/icc_opdecoder.sv
module icc_opdecoder
    import icc_pkg::*;
#(
    parameter int SEL_W = OPC_W,
    localparam int NOUT = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [NOUT-1:0]  onehot
);

    for (genvar n = 0; n < NOUT; n++) begin : g_out
        assign onehot[n] = (sel == SEL_W'(n));
    end

    // R3: exactly one decode line
    always_comb begin
        a_r3_dec_onehot: assert ($countones(onehot) == 1);
    end

endmodule

// File: rtl/icc_datapath.sv
module icc_datapath
    import icc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  dp_ctl_t           ctl,
    input  logic [WORD_W-1:0] rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] ar,
    output instr_t            ir,
    output logic              ibit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ar <= '0;
        end else if (ctl.ar_from_pc) begin
            ar <= pc;
        end else if (ctl.ar_from_ir) begin
            ar <= ir.addr;
        end else if (ctl.ar_from_mem) begin
            ar <= rdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (ctl.pc_inc) begin
            pc <= pc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir <= '0;
        end else if (ctl.ir_load) begin
            ir <= instr_t'(rdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ibit <= 1'b0;
        end else if (ctl.i_load) begin
            ibit <= ir.ind;
        end
    end

    // R4: indirect load takes the low bits of the word read
    a_r4_indirect_load: assert property (@(posedge clk) disable iff (rst)
        ctl.ar_from_mem |=> ar == $past(rdata[ADDR_W-1:0]));

    // R3: PC moves only on the fetch read
    a_r3_pc_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl.pc_inc |=> $stable(pc));

endmodule

// File: rtl/icc_sequencer.sv
module icc_sequencer
    import icc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [11:0]       mem_addr,
    input  logic [15:0]       mem_rdata,
    output logic              mem_rd,
    input  logic              exec_clear,
    output logic [3:0]        step,
    output logic [15:0]       timing,
    output logic [7:0]        dec,
    output logic [1:0]        kind,
    output logic [11:0]       ar,
    output logic [11:0]       pc,
    output logic              ibit,
    output logic              exec_stb,
    output logic              handoff_stb
);

    instr_t  ir;
    dp_ctl_t ctl;
    logic    sc_clear;
    logic    top_line;
    logic    ind_path;
    logic    in_exec;

    icc_step_counter #(.CNT_W(SC_W)) i_counter (
        .clk   (clk),
        .rst   (rst),
        .clear (sc_clear),
        .cnt   (step),
        .lines (timing)
    );

    icc_opdecoder #(.SEL_W(OPC_W)) i_decoder (
        .sel    (ir.opc),
        .onehot (dec)
    );

    icc_datapath i_datapath (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .rdata (mem_rdata),
        .pc    (pc),
        .ar    (ar),
        .ir    (ir),
        .ibit  (ibit)
    );

    assign top_line = dec[DEC_N-1];
    assign ind_path = timing[3] & ~top_line & ibit;
    assign in_exec  = (step >= SC_W'(EXEC_STEP));

    always_comb begin
        ctl             = '0;
        ctl.ar_from_pc  = timing[0];
        ctl.ir_load     = timing[1];
        ctl.pc_inc      = timing[1];
        ctl.ar_from_ir  = timing[2];
        ctl.i_load      = timing[2];
        ctl.ar_from_mem = ind_path;
    end

    assign mem_addr    = ar;
    assign mem_rd      = timing[1] | ind_path;
    assign exec_stb    = timing[3] & top_line;
    assign handoff_stb = timing[EXEC_STEP] & ~top_line;
    assign kind        = classify(top_line, ibit);
    assign sc_clear    = exec_stb | (exec_clear & in_exec);

    // R5: direct memory path leaves AR alone and proceeds to step 4
    a_r5_direct_ar_stable: assert property (@(posedge clk) disable iff (rst)
        (timing[3] && !top_line && !ibit) |=> $stable(ar) && step == 4'd4);

    // R6: register and input-output path returns to step 0
    a_r6_return_to_fetch: assert property (@(posedge clk) disable iff (rst)
        exec_stb |=> step == 4'd0 && $stable(ar));

    // R4: indirect path proceeds to step 4
    a_r4_to_exec: assert property (@(posedge clk) disable iff (rst)
        ind_path |=> step == 4'd4);

    // R9: clear in a fetch step is ignored
    a_r9_early_clear_ignored: assert property (@(posedge clk) disable iff (rst)
        (exec_clear && !in_exec && !exec_stb) |=> step == $past(step) + 1'b1);

    // R2: one timing line at a time
    a_r2_timing_single: assert property (@(posedge clk) disable iff (rst)
        $countones(timing) == 1);

    // R8: both strobes never together
    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(exec_stb && handoff_stb));

endmodule

// File: tb/test_icc_sequencer.sv
module test_icc_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        mem_rd;
    logic        exec_clear = 1'b0;
    logic [3:0]  step;
    logic [15:0] timing;
    logic [7:0]  dec;
    logic [1:0]  kind;
    logic [11:0] ar;
    logic [11:0] pc;
    logic        ibit;
    logic        exec_stb;
    logic        handoff_stb;

    logic [15:0] mem [MEM_WORDS];

    int checks = 0;
    int bad    = 0;
    logic [11:0] exp_pc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    icc_sequencer i_icc_sequencer (
        .clk         (clk),
        .rst         (rst),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .mem_rd      (mem_rd),
        .exec_clear  (exec_clear),
        .step        (step),
        .timing      (timing),
        .dec         (dec),
        .kind        (kind),
        .ar          (ar),
        .pc          (pc),
        .ibit        (ibit),
        .exec_stb    (exec_stb),
        .handoff_stb (handoff_stb)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, expv, $time);
        end
    endtask

    task automatic chk_step(input string tag, input int expv);
        chk(step == 4'(expv), tag, int'(step), expv);
        chk(timing == (16'd1 << expv), {tag, " timing"}, int'(timing), 1 << expv);
    endtask

    // one instruction; called at the negedge in T0; clr_at 0 means let the counter wrap
    task automatic run_instr(input logic [2:0] op, input logic ib,
                             input logic [11:0] adr, input int clr_at);
        logic [11:0] pc0;
        logic [15:0] ptr;
        int          s;
        int          ek;
        pc0 = exp_pc;
        ptr = {4'h3, adr ^ 12'hA5C};
        mem[pc0] = {ib, op, adr};
        mem[adr] = ptr;
        ek = (op == 3'd7) ? (ib ? 3 : 2) : (ib ? 1 : 0);

        chk_step("R2 T0", 0);
        chk(exec_stb == 1'b0 && handoff_stb == 1'b0, "R6 strobes T0", {exec_stb, handoff_stb}, 0);
        @(negedge clk);
        // T1
        chk_step("R2 T1", 1);
        chk(ar == pc0, "R3 AR<=PC", ar, pc0);
        chk(mem_rd == 1'b1, "R3 fetch read", mem_rd, 1);
        chk(mem_addr == pc0, "R3 fetch addr", mem_addr, pc0);
        exec_clear = 1'b1;
        @(negedge clk);
        exec_clear = 1'b0;
        // T2
        chk_step("R9 clear ignored in T1", 2);
        chk(pc == pc0 + 12'd1, "R3 PC increment", pc, pc0 + 12'd1);
        chk(ar == pc0, "R3 AR hold T1", ar, pc0);
        chk(dec == (8'd1 << op), "R3 decode", dec, 1 << op);
        @(negedge clk);
        // T3
        chk_step("R2 T3", 3);
        chk(ar == adr, "R3 AR<=IR addr", ar, adr);
        chk(ibit == ib, "R3 mode flag", ibit, ib);
        chk(kind == 2'(ek), "R7 kind", kind, ek);
        chk(exec_stb == (op == 3'd7), "R6 exec strobe", exec_stb, op == 3'd7);
        chk(mem_rd == (op != 3'd7 && ib), "R4 R5 T3 read", mem_rd, op != 3'd7 && ib);
        chk(handoff_stb == 1'b0, "R8 no handoff T3", handoff_stb, 0);
        @(negedge clk);
        if (op == 3'd7) begin
            chk_step("R6 back to T0", 0);
            chk(ar == adr, "R6 AR hold", ar, adr);
            chk(exec_stb == 1'b0, "R6 strobe one cycle", exec_stb, 0);
        end else begin
            chk_step(ib ? "R4 to T4" : "R5 to T4", 4);
            if (ib) chk(ar == ptr[11:0], "R4 indirect AR", ar, ptr[11:0]);
            else    chk(ar == adr, "R5 direct AR", ar, adr);
            chk(handoff_stb == 1'b1, "R8 handoff T4", handoff_stb, 1);
            chk(mem_rd == 1'b0, "R5 no read T4", mem_rd, 0);
            s = 4;
            while (s != clr_at && s != 0) begin
                @(negedge clk);
                s = (s + 1) % 16;
                chk_step("R2 exec step", s);
                if (s != 0) chk(handoff_stb == 1'b0, "R8 handoff only T4", handoff_stb, 0);
            end
            if (s != 0) begin
                exec_clear = 1'b1;
                @(negedge clk);
                exec_clear = 1'b0;
                chk_step("R9 clear to T0", 0);
            end
        end
        exp_pc = pc0 + 12'd1;
    endtask

    initial begin
        for (int a = 0; a < MEM_WORDS; a++) mem[a] = 16'(a * 37 + 5);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_step("R1 reset step", 0);
        chk(pc == 12'd0 && ar == 12'd0 && ibit == 1'b0, "R1 reset regs",
            {pc, ar, ibit}, 0);
        chk(exec_stb == 1'b0 && handoff_stb == 1'b0, "R1 reset strobes",
            {exec_stb, handoff_stb}, 0);
        for (int r = 0; r < 2; r++) begin
            for (int op = 0; op < 8; op++) begin
                for (int ib = 0; ib < 2; ib++) begin
                    int          ca;
                    logic [11:0] ad;
                    ca = ((op * 2 + ib + r * 5) % 12) + 4;
                    if (r == 1 && op == 2 && ib == 1) ca = 0;
                    ad = 12'(12'h800 + op * 197 + ib * 61 + r * 1000);
                    run_instr(3'(op), 1'(ib), ad, ca);
                end
            end
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_pc = '0;
        chk_step("R1 mid reset", 0);
        chk(pc == 12'd0, "R1 mid reset PC", pc, 0);
        run_instr(3'd5, 1'b1, 12'h123, 6);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule